// File: doc/BRIEF.md
# Receive Frame Status Trailer Generator

This block is the last stage of an Ethernet receive path. It takes received frame bytes on a byte stream and passes them downstream unchanged. After the final byte of each frame it adds four status bytes. Software or a DMA engine can then read the length and health of the frame from the end of the buffer.

Each trailer carries four things: the number of bytes forwarded, which includes the 4 FCS bytes; four error flags collected over the whole frame; and the values of two external statistics counters, captured as the frame ends. The byte count is limited to a programmable maximum. Input bytes past that limit are accepted and discarded, and the overflow flag is set. The output uses valid/ready flow control. While the trailer is being emitted, the input is stalled.

Top module: `rxtrl_gen`

## Requirements
- R1: Every input byte accepted while the frame count is below the limit appears on `out_data`, unchanged and in order. `out_last` is never set on a frame data byte.
- R2: Exactly four trailer bytes follow the forwarded data bytes of every frame, with no gap in the sequence.
- R3: Trailer byte 0 is bits [7:0] of the forwarded byte count. Bits [3:0] of trailer byte 1 are count bits [11:8]. The count includes the FCS bytes, so the header-plus-payload length is the count minus 4.
- R4: Trailer byte 1 holds four error flags, each the OR over every accepted byte of the frame: bit 7 overflow, bit 6 collision, bit 5 framing error, bit 4 FCS error.
- R5: Trailer byte 2 is the 8-bit `runt_cnt` value and trailer byte 3 is the 8-bit `coll_cnt` value. Both are captured in the cycle the input byte with `in_last` is accepted. Later changes to these inputs do not alter the trailer.
- R6: `out_last` is high on trailer byte 3 only.
- R7: The forwarded count saturates at `MAX_COUNT` (default 4095). Input bytes beyond it are accepted but not forwarded. The overflow flag is set, and the count reported equals the number of bytes forwarded.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_valid` hold. After the last input byte is accepted, `in_ready` stays low for the four trailer cycles. No byte is lost under backpressure.
- R9: After reset `out_valid` is low and `in_ready` is high.
- R10: Error flags and the count start from zero for each new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err_ovf | input | 1 | Overflow indication for this byte |
| in_err_col | input | 1 | Collision indication for this byte |
| in_err_fram | input | 1 | Framing error indication for this byte |
| in_err_fcs | input | 1 | FCS error indication for this byte |
| runt_cnt | input | 8 | Current runt packet counter value |
| coll_cnt | input | 8 | Current receive collision counter value |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte (frame data or trailer) |
| out_last | output | 1 | Marks trailer byte 3 |

## Verification
Latency is fixed by the single output register. A byte accepted at one clock edge is visible on `out_data` from that edge onward. After the edge that accepts the last input byte, the four trailer bytes load on the next four edges in which the output slot is free, and `in_ready` returns high on the fifth. The bench drives inputs on the falling edge and reads `in_ready` shortly after. A collector, also running after the falling edge, records only the transfers that the next rising edge completes. Every comparison is therefore made against the actual transfer sequence rather than against cycle guesses, and the in_ready window test samples the five cycles after the last accepted byte directly.

// File: rtl/rxtrl_pkg.sv
package rxtrl_pkg;

  // Trailer field widths are fixed by the trailer layout.
  localparam int CNT_W  = 12;
  localparam int BYTE_W = 8;
  localparam int TRL_LEN = 4;

  typedef enum logic [2:0] {
    ST_DATA   = 3'd0,
    ST_CNT_LO = 3'd1,
    ST_STAT   = 3'd2,
    ST_RUNT   = 3'd3,
    ST_COLL   = 3'd4
  } trl_state_e;

  // Order of members equals bit order in trailer byte 1, [7:4].
  typedef struct packed {
    logic ovf;
    logic col;
    logic fram;
    logic fcs;
  } err_flags_t;

endpackage

// File: rtl/rxtrl_len_ctr.sv
module rxtrl_len_ctr
  import rxtrl_pkg::*;
#(
  parameter int MAX_COUNT = 4095
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_COUNT);

  logic [CNT_W-1:0] cnt_q;

  assign full = (cnt_q == LIMIT);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && !full) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rxtrl_err_acc.sv
module rxtrl_err_acc
  import rxtrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       acc,
  input  logic       drop,
  input  err_flags_t err_in,
  output err_flags_t flags
);

  err_flags_t flags_q;
  err_flags_t add_w;

  always_comb begin
    add_w     = err_in;
    add_w.ovf = err_in.ovf | drop;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flags_q <= '0;
    end else if (acc) begin
      flags_q <= flags_q | add_w;
    end
  end

  assign flags = flags_q;

endmodule

// File: rtl/rxtrl_snap.sv
module rxtrl_snap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/rxtrl_out_stage.sv
module rxtrl_out_stage
  import rxtrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [BYTE_W-1:0] ld_data,
  input  logic              ld_last,
  input  logic              out_ready,
  output logic              slot_free,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);

  logic              vld_q;
  logic [BYTE_W-1:0] dat_q;
  logic              lst_q;

  assign slot_free = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      lst_q <= 1'b0;
    end else if (ld) begin
      vld_q <= 1'b1;
      dat_q <= ld_data;
      lst_q <= ld_last;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_last  = lst_q;

endmodule

// File: rtl/rxtrl_gen.sv
module rxtrl_gen
  import rxtrl_pkg::*;
#(
  parameter int MAX_COUNT = 4095
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_err_ovf,
  input  logic       in_err_col,
  input  logic       in_err_fram,
  input  logic       in_err_fcs,
  input  logic [7:0] runt_cnt,
  input  logic [7:0] coll_cnt,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);

  trl_state_e        state_q, state_d;
  logic              slot_free;
  logic              acc, fwd, drop, frame_end, trl_step, trl_done;
  logic [CNT_W-1:0]  len_cnt;
  logic              len_full;
  err_flags_t        err_in, flags;
  logic [7:0]        runt_q, coll_q;
  logic [7:0]        trl_byte;
  logic              ld;
  logic [7:0]        ld_data;

  assign in_ready  = (state_q == ST_DATA) && slot_free;
  assign acc       = in_valid && in_ready;
  assign fwd       = acc && !len_full;
  assign drop      = acc && len_full;
  assign frame_end = acc && in_last;
  assign trl_step  = (state_q != ST_DATA) && slot_free;
  assign trl_done  = trl_step && (state_q == ST_COLL);

  assign err_in = '{ovf: in_err_ovf, col: in_err_col,
                    fram: in_err_fram, fcs: in_err_fcs};

  rxtrl_len_ctr #(.MAX_COUNT(MAX_COUNT)) u_len (
    .clk (clk), .rst (rst), .clr (trl_done), .inc (acc),
    .cnt (len_cnt), .full (len_full)
  );

  rxtrl_err_acc u_err (
    .clk (clk), .rst (rst), .clr (trl_done), .acc (acc),
    .drop (drop), .err_in (err_in), .flags (flags)
  );

  rxtrl_snap #(.W(8)) u_runt (
    .clk (clk), .rst (rst), .en (frame_end), .d (runt_cnt), .q (runt_q)
  );

  rxtrl_snap #(.W(8)) u_coll (
    .clk (clk), .rst (rst), .en (frame_end), .d (coll_cnt), .q (coll_q)
  );

  always_comb begin
    unique case (state_q)
      ST_CNT_LO: trl_byte = len_cnt[7:0];
      ST_STAT:   trl_byte = {flags, len_cnt[CNT_W-1:8]};
      ST_RUNT:   trl_byte = runt_q;
      ST_COLL:   trl_byte = coll_q;
      default:   trl_byte = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_DATA:   if (frame_end) state_d = ST_CNT_LO;
      ST_CNT_LO: if (slot_free) state_d = ST_STAT;
      ST_STAT:   if (slot_free) state_d = ST_RUNT;
      ST_RUNT:   if (slot_free) state_d = ST_COLL;
      ST_COLL:   if (slot_free) state_d = ST_DATA;
      default:   state_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_DATA;
    else     state_q <= state_d;
  end

  assign ld      = fwd || trl_step;
  assign ld_data = (state_q == ST_DATA) ? in_data : trl_byte;

  rxtrl_out_stage u_out (
    .clk (clk), .rst (rst), .ld (ld), .ld_data (ld_data),
    .ld_last (state_q == ST_COLL), .out_ready (out_ready),
    .slot_free (slot_free), .out_valid (out_valid),
    .out_data (out_data), .out_last (out_last)
  );

endmodule

// File: rtl/rxtrl_gen_chk.sv
module rxtrl_gen_chk #(
  parameter int MAX_COUNT = 4095
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_last,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_last,
  input logic [11:0] len_cnt
);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R8
  trl_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(len_cnt) <= MAX_COUNT);

endmodule

bind rxtrl_gen rxtrl_gen_chk #(.MAX_COUNT(MAX_COUNT)) u_chk (.*);

// File: tb/rxtrl_gen_bench.sv
module rxtrl_gen_bench;

  localparam int MAXC = 4095;
  localparam int NV = 7;
  // {len[12:0], err{ovf,col,fram,fcs}[3:0], runt[7:0], coll[7:0], stall}
  localparam logic [33:0] VEC [NV] = '{
    {13'd1,    4'b0000, 8'h00, 8'h00, 1'b0},
    {13'd60,   4'b0001, 8'h12, 8'h34, 1'b0},
    {13'd64,   4'b0110, 8'hAB, 8'hCD, 1'b1},
    {13'd300,  4'b1000, 8'h7F, 8'h80, 1'b1},
    {13'd4095, 4'b0000, 8'hFF, 8'h01, 1'b0},
    {13'd4100, 4'b0001, 8'h05, 8'h06, 1'b0},
    {13'd20,   4'b0000, 8'h22, 8'h33, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic e_ovf = 1'b0, e_col = 1'b0, e_fram = 1'b0, e_fcs = 1'b0;
  logic [7:0] runt = '0, coll = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  int errors = 0, checks = 0, cyc = 0;
  logic stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  logic [8:0] col_buf [0:8191];
  int n_col = 0;
  logic ir_win [0:4];

  always #10 clk = ~clk;

  rxtrl_gen #(.MAX_COUNT(MAXC)) u_rxtrl_gen (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_data (in_data), .in_last (in_last), .in_err_ovf (e_ovf),
    .in_err_col (e_col), .in_err_fram (e_fram), .in_err_fcs (e_fcs),
    .runt_cnt (runt), .coll_cnt (coll), .out_valid (out_valid),
    .out_ready (out_ready), .out_data (out_data), .out_last (out_last)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (stall_en) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[1];
    end
  end

  always @(negedge clk) begin
    #2;
    if (!rst && out_valid && out_ready) begin
      col_buf[n_col] = {out_last, out_data};
      n_col++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'((i * 7 + v * 13) & 8'hFF);
  endfunction

  task automatic send_frame(input int v, input int len, input logic [3:0] err,
                            input logic [7:0] rv, input logic [7:0] cv);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pat(v, i);
      in_last  = (i == len - 1);
      {e_ovf, e_col, e_fram, e_fcs} = (i == len / 2) ? err : 4'b0000;
      runt = (i == len - 1) ? rv : ~rv;
      coll = (i == len - 1) ? cv : ~cv;
      #1;
      while (!in_ready) begin
        @(negedge clk); #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    {e_ovf, e_col, e_fram, e_fcs} = 4'b0000;
    runt = 8'hEE; coll = 8'hDD;
    for (int j = 0; j < 5; j++) begin
      if (j > 0) @(negedge clk);
      #1 ir_win[j] = in_ready;
    end
  endtask

  task automatic wait_col(input int want);
    int g = 0;
    while (n_col < want && g < 30000) begin
      @(posedge clk); g++;
    end
    repeat (3) @(negedge clk);
    #3;
  endtask

  task automatic check_frame(input int v, input int len, input logic [3:0] err,
                             input logic [7:0] rv, input logic [7:0] cv);
    int fw = (len > MAXC) ? MAXC : len;
    int bad = 0, lasts = 0;
    logic [3:0] fl = err | ((len > MAXC) ? 4'b1000 : 4'b0000);
    logic [11:0] c12 = 12'(fw);
    chk(n_col == fw + 4, "R2", "output byte total", n_col, fw + 4);
    if (n_col == fw + 4) begin
      for (int i = 0; i < fw; i++)
        if (col_buf[i][7:0] != pat(v, i)) bad++;
      for (int i = 0; i < n_col; i++)
        if (col_buf[i][8]) lasts++;
      chk(bad == 0, "R1", "data byte mismatches", bad, 0);
      chk(lasts == 1 && col_buf[fw + 3][8], "R6", "last flags", lasts, 1);
      chk(col_buf[fw][7:0] == c12[7:0], "R3", "count low", int'(col_buf[fw][7:0]), int'(c12[7:0]));
      chk(col_buf[fw+1][3:0] == c12[11:8], "R3", "count high", int'(col_buf[fw+1][3:0]), int'(c12[11:8]));
      chk(col_buf[fw+1][7:4] == fl, "R4", "error flags", int'(col_buf[fw+1][7:4]), int'(fl));
      chk(col_buf[fw+2][7:0] == rv, "R5", "runt snapshot", int'(col_buf[fw+2][7:0]), int'(rv));
      chk(col_buf[fw+3][7:0] == cv, "R5", "collision snapshot", int'(col_buf[fw+3][7:0]), int'(cv));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R9 during reset
    chk(!out_valid, "R9", "out_valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid && in_ready, "R9", "idle after reset", int'({out_valid, in_ready}), 1);

    // Vector table walk (R1..R7, R10 via back-to-back frames)
    for (int v = 0; v < NV; v++) begin
      int len = int'(VEC[v][33:21]);
      n_col = 0;
      stall_en = VEC[v][0];
      out_ready = 1'b1;
      send_frame(v, len, VEC[v][20:17], VEC[v][16:9], VEC[v][8:1]);
      wait_col(((len > MAXC) ? MAXC : len) + 4);
      stall_en = 1'b0;
      out_ready = 1'b1;
      check_frame(v, len, VEC[v][20:17], VEC[v][16:9], VEC[v][8:1]);
      if (len > MAXC) begin
        // R7 saturated count and overflow bit
        chk({col_buf[MAXC+1][3:0], col_buf[MAXC][7:0]} == 12'(MAXC), "R7",
            "saturated count", int'({col_buf[MAXC+1][3:0], col_buf[MAXC][7:0]}), MAXC);
        chk(col_buf[MAXC+1][7], "R7", "overflow bit", int'(col_buf[MAXC+1][7]), 1);
      end
      if (v == NV - 1)
        // R10 flags cleared after prior erroneous frames
        chk(col_buf[21][7:4] == 4'b0000, "R10", "fresh flags", int'(col_buf[21][7:4]), 0);
    end

    // R8: in_ready low for exactly the four trailer cycles
    n_col = 0;
    out_ready = 1'b1;
    send_frame(9, 3, 4'b0000, 8'h01, 8'h02);
    chk(!ir_win[0] && !ir_win[1] && !ir_win[2] && !ir_win[3] && ir_win[4], "R8",
        "in_ready window", int'({ir_win[0], ir_win[1], ir_win[2], ir_win[3], ir_win[4]}), 1);
    wait_col(7);
    check_frame(9, 3, 4'b0000, 8'h01, 8'h02);

    // R8: output holds under backpressure, nothing lost
    n_col = 0;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(out_valid && out_data == 8'hA5 && !in_ready, "R8", "held byte",
          int'(out_data), 8'hA5);
      @(negedge clk);
    end
    out_ready = 1'b1;
    in_valid = 1'b1; in_data = 8'h3C; in_last = 1'b1; runt = 8'h44; coll = 8'h55;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    wait_col(6);
    chk(n_col == 6 && col_buf[0][7:0] == 8'hA5 && col_buf[1][7:0] == 8'h3C,
        "R8", "no byte lost", n_col, 6);
    chk(col_buf[2][7:0] == 8'd2, "R3", "count after stall", int'(col_buf[2][7:0]), 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule